// File: doc/BRIEF.md
# Register-Mapped FIFO SPI Master

This block is an SPI master that a processor drives through a small set of 32-bit registers. Software first holds the shifter back with an inhibit bit in the control register and loads up to sixteen bytes into a transmit queue. It then pulls one slave-select line low through a dedicated register and clears the inhibit bit. The block then shifts the whole queue out, MSB first, eight bits per word, on a single MOSI lane. Every word clocked in on MISO at the same time is stored in a sixteen-entry receive queue, which software drains one byte per read.

SCK is the system clock divided by the even parameter `CLK_DIV`. Its idle level and its sampling edge follow the CPOL and CPHA control bits. Status, receive occupancy and a single interrupt source are provided: the source fires when the transmit queue has drained after a word.

The bus is a plain synchronous strobe interface. A write is taken on the clock edge where `bus_wr` is high. `bus_rdata` is a combinational function of `bus_addr`. A read strobe `bus_rd` only has side effects on the receive-data register.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0x180, status reads 0x5, receive occupancy reads 0, every `ss_n` bit is high, `sck` is low and `irq` is low.
- R2: Writes to the transmit data register (offset 0x68) while control bit 8 (inhibit) is set only queue bytes, and `sck` does not toggle. Status bit 3 (TX full) is set once 16 bytes are held, and a write while full is dropped. Status bit 2 is TX empty and bit 0 is RX empty.
- R3: With control bits 1 (enable) and 2 (master) set and bit 8 clear, queued bytes are shifted out MSB first. With MOSI looped to MISO, the received bytes equal the sent bytes, in the same order.
- R4: The receive occupancy register (offset 0x74) reads the stored byte count minus one, and reads 0 when the queue is empty.
- R5: Each read of the receive data register (offset 0x6C) with `bus_rd` returns the oldest byte in bits 7:0 and removes it.
- R6: With control bit 7 (manual select) set, `ss_n` equals the slave-select register (offset 0x70, active low, one bit per slave), whether or not a transfer is running.
- R7: With control bit 7 clear, `ss_n` is all ones while no transfer is pending or running, and equals the slave-select register during a burst.
- R8: `sck` idles at control bit 3 (CPOL). Control bit 4 (CPHA) = 0 samples MISO on the leading SCK edge; CPHA = 1 samples it on the trailing edge. Loopback transfers are exact in all four modes.
- R9: Each SCK half period lasts `CLK_DIV/2` system clocks.
- R10: Interrupt status bit 0 (offset 0x20) is set when a word finishes with the transmit queue empty. Writing 1 to it clears it.
- R11: `irq` is high exactly when global enable (bit 31 at offset 0x1C) is set and interrupt status bit 0 and interrupt enable bit 0 (offset 0x28) are both set.
- R12: Writing control with bit 5 set empties the transmit queue; with bit 6 set it empties the receive queue. Both bits read back as 0.
- R13: A word that completes while the receive queue holds 16 bytes is discarded, and the stored bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| ss_n | output | NUM_SS | Active-low slave selects |

## Verification
A queue pointer or count gone wrong shows at the ports within one read: occupancy, status flags or the order of the looped-back bytes no longer match what was written. A wrong edge choice in the shifter corrupts the first byte of a loopback burst in the affected CPHA/CPOL mode, so it is visible about `8*CLK_DIV` clocks after the inhibit is released. A bad interrupt or select state is visible on `irq` or `ss_n` in the cycle after the word ends or the register is written.

// File: rtl/spi_fifo_master_pkg.sv
// Shared constants for the register-mapped SPI master: word size,
// register offsets and control bit positions.
package spi_fifo_master_pkg;
    localparam int WORD_W = 8;

    localparam logic [7:0] OFS_GIE    = 8'h1C;
    localparam logic [7:0] OFS_ISR    = 8'h20;
    localparam logic [7:0] OFS_IER    = 8'h28;
    localparam logic [7:0] OFS_CTRL   = 8'h60;
    localparam logic [7:0] OFS_STAT   = 8'h64;
    localparam logic [7:0] OFS_TXD    = 8'h68;
    localparam logic [7:0] OFS_RXD    = 8'h6C;
    localparam logic [7:0] OFS_SSEL   = 8'h70;
    localparam logic [7:0] OFS_RXOCC  = 8'h74;

    localparam int CB_EN     = 1;
    localparam int CB_MASTER = 2;
    localparam int CB_CPOL   = 3;
    localparam int CB_CPHA   = 4;
    localparam int CB_TXRST  = 5;
    localparam int CB_RXRST  = 6;
    localparam int CB_MANSS  = 7;
    localparam int CB_INHIB  = 8;
    localparam int GIE_BIT   = 31;
endpackage

// File: rtl/spi_byte_fifo.sv
// Synchronous first-in first-out queue of WIDTH-bit entries.
// Assumes DEPTH is a power of two. A push while full and a pop while
// empty are ignored. clr empties the queue in one cycle.
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));                                    // R2
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));                                       // R2
endmodule

// File: rtl/spi_shift_engine.sv
// Shifts one WORD_W-bit word per request on a single lane, MSB first.
// A word starts when go is high while idle; the head byte is taken and
// popped in that cycle. CPOL/CPHA are latched at the start of each word.
// Assumes CLK_DIV is even and at least 2.
module spi_shift_engine #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       cpol,
    input  logic       cpha,
    input  logic [spi_fifo_master_pkg::WORD_W-1:0] tx_byte,
    output logic       tx_pop,
    output logic       done,
    output logic [spi_fifo_master_pkg::WORD_W-1:0] rx_byte,
    output logic       busy,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    import spi_fifo_master_pkg::*;
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int NEDG = 2 * WORD_W;
    localparam int ECW  = $clog2(NEDG);
    localparam logic [DW-1:0]  HALF_M1 = DW'(HALF - 1);
    localparam logic [ECW-1:0] EDGE_LAST = ECW'(NEDG - 1);

    logic [DW-1:0]     div_cnt;
    logic [ECW-1:0]    edge_cnt;
    logic [WORD_W-1:0] sh, rx, rx_next;
    logic              mosi_q, sck_q, cpol_q, cpha_q;
    logic              edge_now, leading, sample;

    assign edge_now = busy && (div_cnt == '0);
    assign leading  = !edge_cnt[0];
    assign sample   = leading ^ cpha_q;
    assign rx_next  = {rx[WORD_W-2:0], miso};
    assign tx_pop   = !busy && go;
    assign done     = edge_now && (edge_cnt == EDGE_LAST);
    assign rx_byte  = sample ? rx_next : rx;
    assign sck      = busy ? sck_q : cpol;
    assign mosi     = mosi_q;

    // Word sequencer: load, half-period timing, edge-wise shift and sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sh       <= '0;
            rx       <= '0;
            mosi_q   <= 1'b0;
            sck_q    <= 1'b0;
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
        end else if (!busy) begin
            if (go) begin
                busy     <= 1'b1;
                div_cnt  <= HALF_M1;
                edge_cnt <= '0;
                sck_q    <= cpol;
                cpol_q   <= cpol;
                cpha_q   <= cpha;
                if (cpha) begin
                    sh <= tx_byte;
                end else begin
                    sh     <= {tx_byte[WORD_W-2:0], 1'b0};
                    mosi_q <= tx_byte[WORD_W-1];
                end
            end
        end else if (edge_now) begin
            div_cnt  <= HALF_M1;
            sck_q    <= !sck_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (sample) begin
                rx <= rx_next;
            end else begin
                mosi_q <= sh[WORD_W-1];
                sh     <= {sh[WORD_W-2:0], 1'b0};
            end
            if (edge_cnt == EDGE_LAST) busy <= 1'b0;
        end else begin
            div_cnt <= div_cnt - 1'b1;
        end
    end

    AST_START_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));                              // R3
    AST_SCK_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sck_q != cpol_q));                             // R8
endmodule

// File: rtl/spi_fifo_master.sv
// Register-mapped SPI master: register file, transmit and receive
// queues, slave-select control and interrupt logic around one shift
// engine. Assumes single-cycle bus strobes; reads are combinational and
// only a strobed read of the receive data register has a side effect.
module spi_fifo_master #(
    parameter int FIFO_DEPTH = 16,
    parameter int CLK_DIV    = 4,
    parameter int NUM_SS     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    import spi_fifo_master_pkg::*;
    localparam int CW = $clog2(FIFO_DEPTH+1);

    logic              en_q, master_q, cpol_q, cpha_q, manss_q, inhib_q;
    logic              gie_q, ier_q, isr_q;
    logic [NUM_SS-1:0] ssel_q;

    logic              wr_ctrl, wr_txd, tx_clr, rx_clr, rx_pop;
    logic              tx_pop, tx_empty, tx_full, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, eng_rx;
    logic [CW-1:0]     tx_count, rx_count;
    logic              go, eng_done, eng_busy;
    logic [31:0]       occ_word;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_txd  = bus_wr && (bus_addr == OFS_TXD);
    assign tx_clr  = wr_ctrl && bus_wdata[CB_TXRST];
    assign rx_clr  = wr_ctrl && bus_wdata[CB_RXRST];
    assign rx_pop  = bus_rd && (bus_addr == OFS_RXD);
    assign go      = en_q && master_q && !inhib_q && !tx_empty;

    spi_byte_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(wr_txd), .din(bus_wdata[WORD_W-1:0]),
        .pop(tx_pop), .dout(tx_head), .count(tx_count),
        .empty(tx_empty), .full(tx_full)
    );

    spi_byte_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(eng_done), .din(eng_rx),
        .pop(rx_pop), .dout(rx_head), .count(rx_count),
        .empty(rx_empty), .full(rx_full)
    );

    spi_shift_engine #(.CLK_DIV(CLK_DIV)) i_engine (
        .clk(clk), .rst_n(rst_n), .go(go),
        .cpol(cpol_q), .cpha(cpha_q),
        .tx_byte(tx_head), .tx_pop(tx_pop),
        .done(eng_done), .rx_byte(eng_rx), .busy(eng_busy),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    // Control, enable and slave-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            master_q <= 1'b0;
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            manss_q  <= 1'b1;
            inhib_q  <= 1'b1;
            gie_q    <= 1'b0;
            ier_q    <= 1'b0;
            ssel_q   <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    en_q     <= bus_wdata[CB_EN];
                    master_q <= bus_wdata[CB_MASTER];
                    cpol_q   <= bus_wdata[CB_CPOL];
                    cpha_q   <= bus_wdata[CB_CPHA];
                    manss_q  <= bus_wdata[CB_MANSS];
                    inhib_q  <= bus_wdata[CB_INHIB];
                end
                OFS_GIE:  gie_q  <= bus_wdata[GIE_BIT];
                OFS_IER:  ier_q  <= bus_wdata[0];
                OFS_SSEL: ssel_q <= bus_wdata[NUM_SS-1:0];
                default: ;
            endcase
        end
    end

    // Interrupt status: set on a word ending with the queue drained, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr_q <= 1'b0;
        else if (eng_done && tx_empty)
            isr_q <= 1'b1;
        else if (bus_wr && (bus_addr == OFS_ISR) && bus_wdata[0])
            isr_q <= 1'b0;
    end

    // Interrupt line and slave-select drive.
    always_comb begin
        irq  = gie_q && ier_q && isr_q;
        ss_n = (manss_q || eng_busy || go) ? ssel_q : '1;
    end

    assign occ_word = rx_empty ? 32'd0 : 32'(rx_count) - 32'd1;

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_GIE:   bus_rdata[GIE_BIT] = gie_q;
            OFS_ISR:   bus_rdata[0] = isr_q;
            OFS_IER:   bus_rdata[0] = ier_q;
            OFS_CTRL: begin
                bus_rdata[CB_EN]     = en_q;
                bus_rdata[CB_MASTER] = master_q;
                bus_rdata[CB_CPOL]   = cpol_q;
                bus_rdata[CB_CPHA]   = cpha_q;
                bus_rdata[CB_MANSS]  = manss_q;
                bus_rdata[CB_INHIB]  = inhib_q;
            end
            OFS_STAT:  bus_rdata[3:0] = {tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:   bus_rdata[WORD_W-1:0] = rx_empty ? '0 : rx_head;
            OFS_SSEL:  bus_rdata[NUM_SS-1:0] = ssel_q;
            OFS_RXOCC: bus_rdata = occ_word;
            default: ;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{tx_count, bus_wdata};

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);                                   // R3
    AST_ISR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_q) |-> $past(tx_empty));                       // R10
endmodule

// File: tb/test_spi_fifo_master.sv
// Directed bench: MOSI is looped back to MISO; each task runs one scenario
// and checks its own results through the register interface and pins.
module test_spi_fifo_master;
    localparam int PERIOD  = 10;
    localparam int CLK_DIV = 4;
    localparam int DEPTH   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sck, mosi, miso;
    logic [0:0]  ss_n;

    int checks = 0;
    int errors = 0;
    logic m_cpol = 1'b0, m_cpha = 1'b0, m_man = 1'b1;

    assign miso = mosi;
    always #(PERIOD/2) clk = !clk;

    spi_fifo_master #(.FIFO_DEPTH(DEPTH), .CLK_DIV(CLK_DIV), .NUM_SS(1)) i_spi_fifo_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, input logic strobe);
        @(negedge clk);
        bus_addr = a; bus_rd = strobe;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic inh);
        return 32'h6 | (32'(m_cpol) << 3) | (32'(m_cpha) << 4) | (32'(m_man) << 7) | (32'(inh) << 8);
    endfunction

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'(i * 37 + seed * 11 + 8'h5A);
    endfunction

    task automatic wait_words(input int n);
        repeat (n * (8 * CLK_DIV + 2) + 10) @(negedge clk);
    endtask

    task automatic send_bytes(input int n, input int seed);
        bus_write(8'h60, ctrl_word(1'b1));
        for (int i = 0; i < n; i++) bus_write(8'h68, 32'(pat(i, seed)));
        bus_write(8'h60, ctrl_word(1'b0));
        wait_words(n);
    endtask

    task automatic drain_check(input int n, input int seed, input string tag);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            bus_read(8'h6C, d, 1'b1);
            check(tag, d, 32'(pat(i, seed)));
        end
        bus_read(8'h64, d, 1'b0);
        check({tag, " rx empty after drain"}, d & 32'h1, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(8'h60, d, 1'b0); check("R1 ctrl reset", d, 32'h180);
        bus_read(8'h64, d, 1'b0); check("R1 status reset", d, 32'h5);
        bus_read(8'h74, d, 1'b0); check("R1 occupancy reset", d, 32'h0);
        check("R1 ss_n reset", 32'(ss_n), 32'h1);
        check("R1 sck reset", 32'(sck), 32'h0);
        check("R1 irq reset", 32'(irq), 32'h0);
    endtask

    task automatic t_tx_queue();
        logic [31:0] d;
        int toggles = 0;
        logic last;
        m_cpol = 0; m_cpha = 0; m_man = 1;
        bus_write(8'h70, 32'h0);
        bus_write(8'h60, ctrl_word(1'b1));
        for (int i = 0; i < DEPTH; i++) bus_write(8'h68, 32'(pat(i, 1)));
        bus_write(8'h68, 32'hEE);
        last = sck;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sck !== last) toggles++;
            last = sck;
        end
        check("R2 no sck while inhibited", 32'(toggles), 32'h0);
        bus_read(8'h64, d, 1'b0); check("R2 status tx full", d, 32'h9);
        bus_write(8'h60, ctrl_word(1'b0));
        wait_words(DEPTH + 1);
        bus_read(8'h74, d, 1'b0); check("R4 occupancy full", d, 32'(DEPTH - 1));
        drain_check(DEPTH, 1, "R3 R2 loopback order, 17th dropped");
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            m_cpol = m[0]; m_cpha = m[1]; m_man = 1;
            bus_write(8'h60, ctrl_word(1'b1));
            check("R8 sck idle level", 32'(sck), 32'(m_cpol));
            send_bytes(3, m + 2);
            check("R8 sck idle after word", 32'(sck), 32'(m_cpol));
            drain_check(3, m + 2, "R8 loopback per mode");
        end
        m_cpol = 0; m_cpha = 0;
    endtask

    task automatic t_sck_period();
        time t1, t2;
        bus_write(8'h60, ctrl_word(1'b1));
        bus_write(8'h68, 32'hA5);
        bus_write(8'h60, ctrl_word(1'b0));
        @(sck); @(sck); t1 = $time;
        @(sck); t2 = $time;
        check("R9 sck half period", 32'(t2 - t1), 32'((CLK_DIV / 2) * PERIOD));
        wait_words(1);
        begin
            logic [31:0] d;
            bus_read(8'h6C, d, 1'b1);
            check("R9 byte after period test", d, 32'hA5);
        end
    endtask

    task automatic t_occupancy();
        logic [31:0] d;
        send_bytes(5, 7);
        bus_read(8'h74, d, 1'b0); check("R4 occupancy five", d, 32'h4);
        bus_read(8'h6C, d, 1'b1); check("R5 pop first", d, 32'(pat(0, 7)));
        bus_read(8'h6C, d, 1'b1); check("R5 pop second", d, 32'(pat(1, 7)));
        bus_read(8'h74, d, 1'b0); check("R5 R4 occupancy after pops", d, 32'h2);
        bus_read(8'h6C, d, 1'b1); bus_read(8'h6C, d, 1'b1); bus_read(8'h6C, d, 1'b1);
        bus_read(8'h74, d, 1'b0); check("R4 occupancy empty", d, 32'h0);
    endtask

    task automatic t_slave_select();
        logic [31:0] d;
        m_man = 1;
        bus_write(8'h60, ctrl_word(1'b1));
        bus_write(8'h70, 32'h0);
        check("R6 manual select low", 32'(ss_n), 32'h0);
        bus_write(8'h70, 32'hFFFF_FFFF);
        check("R6 manual deselect", 32'(ss_n), 32'h1);
        m_man = 0;
        bus_write(8'h70, 32'h0);
        bus_write(8'h60, ctrl_word(1'b1));
        check("R7 auto select idle high", 32'(ss_n), 32'h1);
        bus_write(8'h68, 32'h3C);
        bus_write(8'h68, 32'hC3);
        bus_write(8'h60, ctrl_word(1'b0));
        repeat (CLK_DIV * 4) @(negedge clk);
        check("R7 auto select low in burst", 32'(ss_n), 32'h0);
        wait_words(2);
        check("R7 auto select released", 32'(ss_n), 32'h1);
        bus_read(8'h6C, d, 1'b1); check("R7 burst byte 0", d, 32'h3C);
        bus_read(8'h6C, d, 1'b1); check("R7 burst byte 1", d, 32'hC3);
        m_man = 1;
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_write(8'h20, 32'h1);
        bus_write(8'h28, 32'h1);
        bus_write(8'h1C, 32'h0);
        send_bytes(2, 9);
        bus_read(8'h20, d, 1'b0); check("R10 isr set after drain", d, 32'h1);
        check("R11 irq gated by global enable", 32'(irq), 32'h0);
        bus_write(8'h1C, 32'h8000_0000);
        check("R11 irq asserted", 32'(irq), 32'h1);
        bus_write(8'h28, 32'h0);
        check("R11 irq gated by enable", 32'(irq), 32'h0);
        bus_write(8'h28, 32'h1);
        bus_write(8'h20, 32'h1);
        bus_read(8'h20, d, 1'b0); check("R10 isr cleared", d, 32'h0);
        check("R11 irq after clear", 32'(irq), 32'h0);
        drain_check(2, 9, "R10 bytes");
        bus_write(8'h1C, 32'h0);
    endtask

    task automatic t_fifo_reset();
        logic [31:0] d;
        bus_write(8'h60, ctrl_word(1'b1));
        bus_write(8'h68, 32'h11); bus_write(8'h68, 32'h22); bus_write(8'h68, 32'h33);
        bus_write(8'h60, ctrl_word(1'b1) | 32'h20);
        bus_read(8'h64, d, 1'b0); check("R12 tx flushed", d & 32'h4, 32'h4);
        bus_read(8'h60, d, 1'b0); check("R12 reset bits read zero", d & 32'h60, 32'h0);
        send_bytes(4, 3);
        bus_write(8'h60, ctrl_word(1'b1) | 32'h40);
        bus_read(8'h64, d, 1'b0); check("R12 rx flushed", d, 32'h5);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        send_bytes(DEPTH, 4);
        bus_write(8'h60, ctrl_word(1'b1));
        bus_write(8'h68, 32'h99);
        bus_write(8'h60, ctrl_word(1'b0));
        wait_words(1);
        bus_read(8'h64, d, 1'b0); check("R13 status rx full", d, 32'h6);
        drain_check(DEPTH, 4, "R13 stored bytes kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_queue();
        t_modes();
        t_sck_period();
        t_occupancy();
        t_slave_select();
        t_irq();
        t_fifo_reset();
        t_rx_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule